// File: doc/BRIEF.md
# I2C SCL Phase Generator

This block produces the clock-line timing for an I2C master engine. Two 9-bit counts set the length of the low phase and of the high phase of SCL. The low 8 bits of each count arrive on their own ports. The ninth bits are the top two bits of the interrupt-enable register: bit 7 extends the low count and bit 6 extends the high count. A build parameter can drop support for the ninth bit, which caps both counts at 255. A configuration pin selects a count clock equal to the module clock or half of it.

The low phase begins at the moment the block asks for SCL to be pulled low. The high phase is counted only after the sensed SCL line reads high. The rise time therefore adds no error, and a slave that stretches the clock holds the generator in place. A single-cycle strobe marks the last cycle of each low phase so the engine can change SDA. A second strobe marks the middle tick of the high phase so the engine can sample SDA.

All pins are plain control and status levels. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is held, and after it is released, the SCL pull request and both strobes are 0.
- R2: With run high, the generator stays released until a one-cycle start request is seen. The pull request goes high in the cycle after the start is sampled. A start seen while run is low is ignored.
- R3: The low phase holds the pull request high for exactly N_low × D clock cycles. D is 1 when the divide pin is 0 and 2 when it is 1.
- R4: After the pull request drops, the high count begins only in the cycle after the sensed SCL reads high. If the line is held low for S cycles after release, the released time is S + 1 + N_high × D cycles before the next low phase.
- R5: With ninth-bit support (the default), N_low = {low_bit8, low_cnt} and N_high = {high_bit8, high_cnt}, where the bit-8 pins are bits 7 and 6 of the interrupt-enable register. Without support, the bit-8 pins are ignored and the counts never exceed 255.
- R6: A count of 0 behaves as 1, so a phase always lasts at least D cycles.
- R7: When the divide pin is 1, the count tick never fires in two consecutive cycles.
- R8: The SDA-update strobe is high for exactly one cycle, and that cycle is the last cycle of each low phase.
- R9: The SDA-sample strobe is high for one cycle on tick number ceil(N_high/2) of the high count. That is released-cycle index S + ceil(N_high/2) × D, counted from 0 at the first released cycle.
- R10: Dropping run returns the generator to idle in the next cycle, with SCL released and no strobes. The generator then needs a new start to resume.
- R11: Each count is captured when its phase begins. A change to a count input during a phase affects only the next phase of that kind.
- R12: While run stays high, each high phase is followed directly by a new low phase without another start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Engine running; low forces idle |
| start_i | input | 1 | One-cycle request to begin clocking |
| low_cnt_i | input | 8 | Low-phase count, bits 7:0 |
| high_cnt_i | input | 8 | High-phase count, bits 7:0 |
| low_bit8_i | input | 1 | Low-phase count bit 8 (interrupt-enable register bit 7) |
| high_bit8_i | input | 1 | High-phase count bit 8 (interrupt-enable register bit 6) |
| div2_i | input | 1 | 1 selects a count clock of half the module clock |
| scl_sense_i | input | 1 | Sensed level of the SCL line |
| scl_pull_o | output | 1 | Request to drive SCL low |
| sda_update_o | output | 1 | Strobe on the last cycle of a low phase |
| sda_sample_o | output | 1 | Strobe at the middle tick of a high phase |

## Verification
The hardest case to reach from the ports is a high phase whose start is delayed by a slave holding SCL low. This must be told apart from an early start that still happens to land on the right total length. The bench models the line with a programmable hold time after each release. It checks both the released length and the exact released-cycle index of the sample strobe, and it sweeps the hold time with random counts and both divide settings. A count changed in the middle of a low phase, and run dropped inside a low phase, are driven at chosen negative edges to reach the capture and abort paths.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOW    = 2'd1,
    PH_WAITHI = 2'd2,
    PH_HIGH   = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_count_cfg.sv
module scl_count_cfg #(
  parameter int LSB_W   = 8,
  parameter bit EXT_BIT = 1'b1,
  localparam int CW     = LSB_W + 1
) (
  input  logic [LSB_W-1:0] low_lsb,
  input  logic [LSB_W-1:0] high_lsb,
  input  logic             low_msb,
  input  logic             high_msb,
  output logic [CW-1:0]    low_n,
  output logic [CW-1:0]    high_n
);
  logic [CW-1:0] low_raw, high_raw;

  generate
    if (EXT_BIT) begin : g_wide
      assign low_raw  = {low_msb, low_lsb};
      assign high_raw = {high_msb, high_lsb};
    end else begin : g_narrow
      logic unused_msb;
      assign unused_msb = low_msb ^ high_msb;
      assign low_raw  = {1'b0, low_lsb};
      assign high_raw = {1'b0, high_lsb};
    end
  endgenerate

  // a zero count is stretched to a single tick
  assign low_n  = (low_raw  == '0) ? CW'(1) : low_raw;
  assign high_n = (high_raw == '0) ? CW'(1) : high_raw;
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic div2,
  output logic tick
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half_q <= 1'b0;
    else if (clr)    half_q <= 1'b0;
    else if (div2)   half_q <= ~half_q;
    else             half_q <= 1'b0;
  end

  assign tick = div2 ? half_q : 1'b1;

  // R7: the halved count clock never ticks on back-to-back cycles
  assert_half_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div2 && tick) |=> (!tick || !div2));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic          scl_in,
  input  logic [CW-1:0] low_n,
  input  logic [CW-1:0] high_n,
  input  logic          tick,
  output logic          pre_clr,
  output phase_e        phase,
  output logic          update_stb,
  output logic          sample_stb
);
  phase_e        st, st_nx;
  logic [CW-1:0] cnt, cnt_nx, tgt, tgt_nx;
  logic [CW:0]   cnt_p1, mid;
  logic          last;

  assign cnt_p1 = {1'b0, cnt} + 1'b1;
  assign mid    = ({1'b0, tgt} + 1'b1) >> 1;
  assign last   = tick && (cnt_p1 == {1'b0, tgt});

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    tgt_nx = tgt;
    if (!run) begin
      st_nx = PH_IDLE;
    end else begin
      unique case (st)
        PH_IDLE: if (start) begin
          st_nx = PH_LOW; tgt_nx = low_n; cnt_nx = '0;
        end
        PH_LOW: begin
          if (last)      st_nx = PH_WAITHI;
          else if (tick) cnt_nx = cnt_p1[CW-1:0];
        end
        PH_WAITHI: if (scl_in) begin
          st_nx = PH_HIGH; tgt_nx = high_n; cnt_nx = '0;
        end
        PH_HIGH: begin
          if (last) begin
            st_nx = PH_LOW; tgt_nx = low_n; cnt_nx = '0;
          end else if (tick) cnt_nx = cnt_p1[CW-1:0];
        end
        default: st_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PH_IDLE;
      cnt <= '0;
      tgt <= CW'(1);
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      tgt <= tgt_nx;
    end
  end

  assign pre_clr    = (st_nx != st) || !(st == PH_LOW || st == PH_HIGH);
  assign phase      = st;
  assign update_stb = (st == PH_LOW) && last;
  assign sample_stb = (st == PH_HIGH) && tick && (cnt_p1 == mid);

  // R4: counting of the high phase only follows a high reading of the line
  assert_high_after_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_HIGH && $past(st) == PH_WAITHI) |-> $past(scl_in));
  // R3: the running count stays below its captured target
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_LOW || st == PH_HIGH) |-> (cnt < tgt));
  // R10: loss of run forces idle on the next cycle
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (st == PH_IDLE));
  // R2: idle persists without a start request
  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_IDLE && !start) |=> (st == PH_IDLE));
  // R8: the update strobe hands over to the wait-for-line phase
  assert_update_handoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (update_stb && run) |=> (st == PH_WAITHI));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int LSB_W   = 8,
  parameter bit EXT_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [LSB_W-1:0] low_cnt_i,
  input  logic [LSB_W-1:0] high_cnt_i,
  input  logic             low_bit8_i,
  input  logic             high_bit8_i,
  input  logic             div2_i,
  input  logic             scl_sense_i,
  output logic             scl_pull_o,
  output logic             sda_update_o,
  output logic             sda_sample_o
);
  localparam int CW = LSB_W + 1;

  logic [CW-1:0] low_n, high_n;
  logic          tick, pre_clr;
  phase_e        phase;

  scl_count_cfg #(.LSB_W(LSB_W), .EXT_BIT(EXT_BIT)) u_cfg (
    .low_lsb  (low_cnt_i),
    .high_lsb (high_cnt_i),
    .low_msb  (low_bit8_i),
    .high_msb (high_bit8_i),
    .low_n    (low_n),
    .high_n   (high_n)
  );

  scl_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pre_clr),
    .div2  (div2_i),
    .tick  (tick)
  );

  scl_phase_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_i),
    .start      (start_i),
    .scl_in     (scl_sense_i),
    .low_n      (low_n),
    .high_n     (high_n),
    .tick       (tick),
    .pre_clr    (pre_clr),
    .phase      (phase),
    .update_stb (sda_update_o),
    .sample_stb (sda_sample_o)
  );

  assign scl_pull_o = (phase == PH_LOW);

  // R9: sampling happens only while the line is released
  assert_sample_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_o |-> !scl_pull_o);
  // R5: without the ninth bit both counts fit in the low byte
  assert_narrow_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !EXT_BIT |-> (low_n[CW-1] == 1'b0 && high_n[CW-1] == 1'b0));
endmodule

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, run = 1'b0, start = 1'b0, div2 = 1'b0;
  logic [7:0] lo8 = 8'd0, hi8 = 8'd0;
  logic       lob8 = 1'b0, hib8 = 1'b0;
  logic       dl_w, up_w, sm_w, dl_n, up_n, sm_n, scl_w, scl_n;
  int         stretch = 0;
  int         rel_age = 0;
  int         errors = 0, checks = 0;

  scl_phase_gen u_scl_phase_gen (
    .clk(clk), .rst_n(rst_n), .run_i(run), .start_i(start),
    .low_cnt_i(lo8), .high_cnt_i(hi8), .low_bit8_i(lob8), .high_bit8_i(hib8),
    .div2_i(div2), .scl_sense_i(scl_w),
    .scl_pull_o(dl_w), .sda_update_o(up_w), .sda_sample_o(sm_w));

  scl_phase_gen #(.EXT_BIT(1'b0)) u_scl_phase_gen_narrow (
    .clk(clk), .rst_n(rst_n), .run_i(run), .start_i(start),
    .low_cnt_i(lo8), .high_cnt_i(hi8), .low_bit8_i(lob8), .high_bit8_i(hib8),
    .div2_i(div2), .scl_sense_i(scl_n),
    .scl_pull_o(dl_n), .sda_update_o(up_n), .sda_sample_o(sm_n));

  // line model: released line rises after 'stretch' cycles
  always_ff @(posedge clk) rel_age <= dl_w ? 0 : ((rel_age < 100000) ? rel_age + 1 : rel_age);
  assign scl_w = !dl_w && (rel_age >= stretch);
  assign scl_n = !dl_n;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input bit b8, input logic [7:0] v, input bit ext);
    int n;
    n = ext ? {b8, v} : int'(v);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic bit cur_dl(input bit sel); return sel ? dl_n : dl_w; endfunction
  function automatic bit cur_up(input bit sel); return sel ? up_n : up_w; endfunction
  function automatic bit cur_sm(input bit sel); return sel ? sm_n : sm_w; endfunction

  task automatic measure(input bit sel, output int lo, output int hi,
                         output int upos, output int spos);
    lo = 0; hi = 0; upos = -1; spos = -1;
    @(negedge clk);
    while (cur_dl(sel)) @(negedge clk);
    while (!cur_dl(sel)) @(negedge clk);
    while (cur_dl(sel)) begin
      lo++;
      if (cur_up(sel)) upos = lo;
      @(negedge clk);
    end
    while (!cur_dl(sel)) begin
      if (cur_sm(sel)) spos = hi;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input string tag);
    int lo, hi, up, sp, nl, nh, d, m;
    measure(1'b0, lo, hi, up, sp);
    nl = eff(lob8, lo8, 1'b1);
    nh = eff(hib8, hi8, 1'b1);
    d  = div2 ? 2 : 1;
    m  = (nh + 1) / 2;
    check(lo == nl * d, {tag, " R3 low length"}, lo, nl * d);
    check(hi == stretch + 1 + nh * d, {tag, " R4 released length"}, hi, stretch + 1 + nh * d);
    check(up == lo, {tag, " R8 update strobe position"}, up, lo);
    check(sp == stretch + m * d, {tag, " R9 sample strobe index"}, sp, stretch + m * d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lo, hi, up, sp, cnt;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!dl_w && !up_w && !sm_w, "R1 outputs in reset", dl_w, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!dl_w && !up_w && !sm_w, "R1 outputs after reset", dl_w, 0);

    // start without run is ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    check(!dl_w, "R2 start ignored without run", dl_w, 0);
    run = 1'b1;
    repeat (10) @(negedge clk);
    check(!dl_w, "R2 idle until start", dl_w, 0);
    lo8 = 8'd4; hi8 = 8'd3;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(dl_w, "R2 pull one cycle after start", dl_w, 1);

    // zero counts
    lo8 = 8'd0; hi8 = 8'd0; stretch = 0; div2 = 1'b0;
    run_case("zero-d1 R6");
    div2 = 1'b1;
    run_case("zero-d2 R6 R7");
    // continuous cycling without a new start
    measure(1'b0, lo, hi, up, sp);
    check(lo == 2, "R12 back-to-back low phase", lo, 2);

    // ninth bits at maximum, stretched line
    lo8 = 8'hFF; hi8 = 8'hFF; lob8 = 1'b1; hib8 = 1'b1; stretch = 3; div2 = 1'b0;
    run_case("max9 R5");
    lo8 = 8'd5; hi8 = 8'd3; lob8 = 1'b1; hib8 = 1'b0; stretch = 0;
    run_case("bit8-low R5");
    // narrow build ignores the ninth bits
    lob8 = 1'b1; hib8 = 1'b1;
    measure(1'b1, lo, hi, up, sp);
    check(lo == 5, "R5 narrow ignores low bit8", lo, 5);
    check(hi == 4, "R5 narrow ignores high bit8", hi, 4);
    lob8 = 1'b0; hib8 = 1'b0;

    // random sweep
    for (int i = 0; i < 24; i++) begin
      lo8 = 8'($urandom_range(0, 40));
      hi8 = 8'($urandom_range(0, 40));
      div2 = 1'($urandom_range(0, 1));
      stretch = $urandom_range(0, 6);
      run_case("random R3 R4 R7");
    end

    // R11: change count during a low phase
    div2 = 1'b0; stretch = 0; lo8 = 8'd30; hi8 = 8'd2;
    @(negedge clk);
    while (dl_w) @(negedge clk);
    while (!dl_w) @(negedge clk);
    cnt = 0;
    while (dl_w) begin
      cnt++;
      if (cnt == 3) lo8 = 8'd7;
      @(negedge clk);
    end
    check(cnt == 30, "R11 count captured at phase entry", cnt, 30);
    measure(1'b0, lo, hi, up, sp);
    check(lo == 7, "R11 new count used next phase", lo, 7);

    // R10: abort inside a low phase
    lo8 = 8'd20;
    while (!dl_w) @(negedge clk);
    repeat (2) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(!dl_w && !up_w && !sm_w, "R10 released after run drop", dl_w, 0);
    run = 1'b1;
    repeat (10) @(negedge clk);
    check(!dl_w, "R10 needs new start", dl_w, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(dl_w, "R10 restart after start", dl_w, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule